// File: doc/BRIEF.md
# Block Protection State Controller

This block holds the erase/program protection state of every block of a parallel flash array, 24 blocks by default. Each block stores a lock bit and a lock-down bit. Both are read together with one global write-protect level that the block samples every clock. Lock commands come from an upstream command parser already reduced to a valid strobe, a two-bit operation code and a block index. Edges on the write-protect level move the blocks that are locked down between their protected and lock-down-disabled forms.

Two combinational read ports face the rest of the flash controller. The query port tells the erase/program sequencer whether the addressed block may be modified. The configuration port returns the two protection bits of a block in the word that an identifier read places on the data bus. Each block also keeps one history bit. It records whether the block was locked down but unlocked when write-protect last fell, so that the next rising edge can restore that unlocked state.

Top module: `blk_prot_ctrl`

## Requirements
- R1: After reset every block reads as locked and not locked down (configuration word 0x0001), and erase/program is refused for it.
- R2: Erase/program is allowed for a valid block exactly when its lock bit is clear. These are the states {wp,ldn,lock} = 000, 100 and 110.
- R3: Operation code 00 (set lock) sets the lock bit. Operation code 01 (clear lock) clears it, except when the block is locked down and write-protect is low.
- R4: Operation code 10 (set lock-down) sets both the lock-down bit and the lock bit, at either write-protect level. The lock-down bit is then only cleared by reset.
- R5: A block that is locked down while write-protect is low (state 011) is not changed by any lock command.
- R6: On a rising write-protect edge a locked-down block goes to 110 if it was in 110 just before the most recent falling edge, and to 111 otherwise. Blocks that are not locked down keep their bits.
- R7: On a falling write-protect edge every locked-down block is forced locked (110 and 111 both become 011). Other blocks keep their bits.
- R8: The configuration word carries the lock bit on bit 0 and the lock-down bit on bit 1, with all upper bits zero.
- R9: When a write-protect edge and a lock command hit the same block in one cycle, the edge is applied first and the command then acts on the result at the new level.
- R10: A command whose block index is 24 or above changes nothing. For such an index the query reports not allowed and the configuration word reads 0.
- R11: Operation code 11 changes nothing, and a command changes only the block it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_lvl | input | 1 | Global write-protect level, 1 = lock-down disabled |
| cmd_vld | input | 1 | Lock command strobe, one cycle per command |
| cmd_op | input | 2 | 00 set lock, 01 clear lock, 10 set lock-down, 11 reserved |
| cmd_blk | input | 5 | Block index of the command |
| qry_blk | input | 5 | Block index for the erase/program permission query |
| qry_ok | output | 1 | 1 when erase/program is allowed on qry_blk |
| cfg_blk | input | 5 | Block index for the configuration read |
| cfg_data | output | 16 | Configuration word of cfg_blk |

## Verification
The hardest state to reach is the one that depends on history. A block is unlocked in 110, write-protect falls so it becomes 011, and a rising edge must then bring back 110 rather than 111. The bench builds this with a chain of commands at high write-protect: clear, lock-down, then clear. It then toggles the level twice, and repeats the toggles after relocking to show that the history is overwritten. A second sequence applies a rising edge and a clear-lock command in the same cycle. The result is 110 only if the edge is applied first.

// File: rtl/blk_prot_pkg.sv
package blk_prot_pkg;

  // Operation codes presented with cmd_vld
  typedef enum logic [1:0] {
    OP_SET_LOCK = 2'b00,
    OP_CLR_LOCK = 2'b01,
    OP_SET_LDN  = 2'b10,
    OP_RSVD     = 2'b11
  } lock_op_e;

endpackage

// File: rtl/blk_prot_wp_edge.sv
// Registers the write-protect level and flags its edges for one cycle.
module blk_prot_wp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_in,
  output logic wp_q,
  output logic wp_rise,
  output logic wp_fall
);

  logic wp_d;

  always_comb begin
    wp_d    = wp_in;
    wp_rise = wp_in & ~wp_q;
    wp_fall = ~wp_in & wp_q;
  end

  // The sampled level starts low; a high level at reset release shows up as
  // a rise that cannot touch any block, since no lock-down bit is set yet.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= 1'b0;
    end else begin
      wp_q <= wp_d;
    end
  end

endmodule

// File: rtl/blk_prot_cell.sv
// Protection state of a single flash block: lock, lock-down and history bit.
module blk_prot_cell
  import blk_prot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wp_now,
  input  logic       wp_rise,
  input  logic       wp_fall,
  input  logic       cmd_hit,
  input  logic [1:0] cmd_op,
  output logic       lock_q,
  output logic       ldn_q
);

  logic     hist_q;
  logic     lock_e, ldn_e;
  logic     lock_d, ldn_d, hist_d;
  logic     upd_en;
  lock_op_e op;

  assign op = lock_op_e'(cmd_op);

  always_comb begin
    // stage 1: level edges
    lock_e = lock_q;
    ldn_e  = ldn_q;
    hist_d = hist_q;
    if (wp_rise && ldn_q) begin
      lock_e = ~hist_q;
    end
    if (wp_fall) begin
      hist_d = ldn_q & ~lock_q;
      if (ldn_q) begin
        lock_e = 1'b1;
      end
    end

    // stage 2: command at the new level
    lock_d = lock_e;
    ldn_d  = ldn_e;
    if (cmd_hit) begin
      case (op)
        OP_SET_LOCK: lock_d = 1'b1;
        OP_CLR_LOCK: begin
          if (!(ldn_e && !wp_now)) begin
            lock_d = 1'b0;
          end
        end
        OP_SET_LDN: begin
          lock_d = 1'b1;
          ldn_d  = 1'b1;
        end
        default: begin
          lock_d = lock_e;
        end
      endcase
    end

    upd_en = cmd_hit | wp_rise | wp_fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b1;
      ldn_q  <= 1'b0;
      hist_q <= 1'b0;
    end else if (upd_en) begin
      lock_q <= lock_d;
      ldn_q  <= ldn_d;
      hist_q <= hist_d;
    end
  end

endmodule

// File: rtl/blk_prot_rd.sv
// Combinational read side: permission query and configuration word.
module blk_prot_rd #(
  parameter int NUM_BLK = 24,
  parameter int IDX_W   = 5,
  parameter int CFG_W   = 16
) (
  input  logic [NUM_BLK-1:0] lock_v,
  input  logic [NUM_BLK-1:0] ldn_v,
  input  logic [IDX_W-1:0]   qry_sel,
  output logic               qry_ok,
  input  logic [IDX_W-1:0]   cfg_sel,
  output logic [CFG_W-1:0]   cfg_word
);

  localparam logic [IDX_W:0] BLK_LIM = (IDX_W + 1)'(NUM_BLK);

  logic qry_in, cfg_in;

  always_comb begin
    qry_in   = {1'b0, qry_sel} < BLK_LIM;
    cfg_in   = {1'b0, cfg_sel} < BLK_LIM;
    qry_ok   = 1'b0;
    cfg_word = '0;
    if (qry_in) begin
      qry_ok = ~lock_v[qry_sel];
    end
    if (cfg_in) begin
      cfg_word[0] = lock_v[cfg_sel];
      cfg_word[1] = ldn_v[cfg_sel];
    end
  end

endmodule

// File: rtl/blk_prot_ctrl.sv
// Per-block lock / lock-down controller for a flash array.
module blk_prot_ctrl #(
  parameter int NUM_BLK = 24,
  parameter int IDX_W   = $clog2(NUM_BLK),
  parameter int CFG_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wp_lvl,
  input  logic             cmd_vld,
  input  logic [1:0]       cmd_op,
  input  logic [IDX_W-1:0] cmd_blk,
  input  logic [IDX_W-1:0] qry_blk,
  output logic             qry_ok,
  input  logic [IDX_W-1:0] cfg_blk,
  output logic [CFG_W-1:0] cfg_data
);

  logic               wp_lvl_q;
  logic               wp_rise, wp_fall;
  logic [NUM_BLK-1:0] cmd_hit;
  logic [NUM_BLK-1:0] lock_vec;
  logic [NUM_BLK-1:0] ldn_vec;

  blk_prot_wp_edge u_wp (
    .clk    (clk),
    .rst_n  (rst_n),
    .wp_in  (wp_lvl),
    .wp_q   (wp_lvl_q),
    .wp_rise(wp_rise),
    .wp_fall(wp_fall)
  );

  for (genvar gi = 0; gi < NUM_BLK; gi++) begin : g_blk
    localparam logic [IDX_W-1:0] BLK_ID = IDX_W'(gi);

    assign cmd_hit[gi] = cmd_vld && (cmd_blk == BLK_ID);

    blk_prot_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .wp_now (wp_lvl),
      .wp_rise(wp_rise),
      .wp_fall(wp_fall),
      .cmd_hit(cmd_hit[gi]),
      .cmd_op (cmd_op),
      .lock_q (lock_vec[gi]),
      .ldn_q  (ldn_vec[gi])
    );
  end

  blk_prot_rd #(
    .NUM_BLK(NUM_BLK),
    .IDX_W  (IDX_W),
    .CFG_W  (CFG_W)
  ) u_rd (
    .lock_v  (lock_vec),
    .ldn_v   (ldn_vec),
    .qry_sel (qry_blk),
    .qry_ok  (qry_ok),
    .cfg_sel (cfg_blk),
    .cfg_word(cfg_data)
  );

endmodule

// File: rtl/blk_prot_chk.sv
// Property checker bound into blk_prot_ctrl.
module blk_prot_chk #(
  parameter int NUM_BLK = 24,
  parameter int IDX_W   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wp_lvl,
  input logic               cmd_vld,
  input logic [1:0]         cmd_op,
  input logic [IDX_W-1:0]   cmd_blk,
  input logic               wp_q,
  input logic [NUM_BLK-1:0] lock_vec,
  input logic [NUM_BLK-1:0] ldn_vec
);

  for (genvar gi = 0; gi < NUM_BLK; gi++) begin : g_chk
    localparam logic [IDX_W-1:0] BI = IDX_W'(gi);

    p_ldn_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ldn_vec[gi] |=> ldn_vec[gi]);

    p_set_ldn_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && cmd_op == 2'b10 && cmd_blk == BI) |=> (ldn_vec[gi] && lock_vec[gi]));

    p_set_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && cmd_op == 2'b00 && cmd_blk == BI) |=> lock_vec[gi]);

    p_ldn_low_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ldn_vec[gi] && !wp_q) |-> lock_vec[gi]);

    p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ldn_vec[gi] && !wp_q && !wp_lvl) |=> (ldn_vec[gi] && lock_vec[gi]));

    p_untouched_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!(cmd_vld && cmd_blk == BI) && wp_lvl == wp_q)
        |=> ($stable(lock_vec[gi]) && $stable(ldn_vec[gi])));
  end

endmodule

bind blk_prot_ctrl blk_prot_chk #(
  .NUM_BLK(NUM_BLK),
  .IDX_W  (IDX_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wp_lvl  (wp_lvl),
  .cmd_vld (cmd_vld),
  .cmd_op  (cmd_op),
  .cmd_blk (cmd_blk),
  .wp_q    (wp_lvl_q),
  .lock_vec(lock_vec),
  .ldn_vec (ldn_vec)
);

// File: tb/blk_prot_ctrl_tb_top.sv
`timescale 1ns/1ps
module blk_prot_ctrl_tb_top;

  localparam int IDX_W = 5;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             wp_lvl;
  logic             cmd_vld;
  logic [1:0]       cmd_op;
  logic [IDX_W-1:0] cmd_blk;
  logic [IDX_W-1:0] qry_blk;
  logic             qry_ok;
  logic [IDX_W-1:0] cfg_blk;
  logic [15:0]      cfg_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  blk_prot_ctrl dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wp_lvl  (wp_lvl),
    .cmd_vld (cmd_vld),
    .cmd_op  (cmd_op),
    .cmd_blk (cmd_blk),
    .qry_blk (qry_blk),
    .qry_ok  (qry_ok),
    .cfg_blk (cfg_blk),
    .cfg_data(cfg_data)
  );

  // Compare configuration word and permission of one block.
  // Expected permission is the inverse of the lock bit (R2).
  task automatic chk_blk(input int blk, input logic [15:0] exp_cfg, input string tag);
    logic exp_ok;
    exp_ok  = (blk < 24) ? ~exp_cfg[0] : 1'b0;
    qry_blk = IDX_W'(blk);
    cfg_blk = IDX_W'(blk);
    #1;
    n_chk++;
    if (cfg_data !== exp_cfg || qry_ok !== exp_ok) begin
      n_fail++;
      $display("FAIL %s blk %0d: cfg=%h ok=%b expected cfg=%h ok=%b",
               tag, blk, cfg_data, qry_ok, exp_cfg, exp_ok);
    end
  endtask

  task automatic do_cmd(input logic [1:0] op, input int blk);
    @(negedge clk);
    cmd_vld = 1'b1;
    cmd_op  = op;
    cmd_blk = IDX_W'(blk);
    @(negedge clk);
    cmd_vld = 1'b0;
  endtask

  task automatic set_wp(input logic v);
    @(negedge clk);
    wp_lvl = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk_blk(0,  16'h0001, "R1 reset");
    chk_blk(23, 16'h0001, "R1 reset last block");
  endtask

  task automatic t_lock_cmds;
    do_cmd(2'b01, 0);
    chk_blk(0, 16'h0000, "R3 clear lock wp low, R2 allowed");
    do_cmd(2'b00, 0);
    chk_blk(0, 16'h0001, "R3 set lock");
    do_cmd(2'b01, 0);
    chk_blk(1, 16'h0001, "R11 other block untouched");
    do_cmd(2'b11, 0);
    chk_blk(0, 16'h0000, "R11 reserved op ignored");
  endtask

  task automatic t_lockdown_low;
    do_cmd(2'b10, 2);
    chk_blk(2, 16'h0003, "R4 lock-down from locked, R8 format");
    do_cmd(2'b10, 0);
    chk_blk(0, 16'h0003, "R4 lock-down locks unlocked block");
    do_cmd(2'b01, 2);
    chk_blk(2, 16'h0003, "R5 clear ignored in 011");
    do_cmd(2'b00, 2);
    chk_blk(2, 16'h0003, "R5 set lock no change in 011");
  endtask

  task automatic t_range;
    do_cmd(2'b01, 31);
    chk_blk(31, 16'h0000, "R10 out of range reads zero, not allowed");
    chk_blk(23, 16'h0001, "R10 command beyond range ignored");
    do_cmd(2'b01, 24);
    chk_blk(24, 16'h0000, "R10 index 24");
    chk_blk(23, 16'h0001, "R10 index 24 ignored");
  endtask

  task automatic t_rise_fall;
    set_wp(1'b1);
    chk_blk(1, 16'h0001, "R6 rise keeps non-lock-down block");
    chk_blk(2, 16'h0003, "R6 rise from 011 without history gives 111");
    do_cmd(2'b01, 1);
    chk_blk(1, 16'h0000, "R3 clear at wp high");
    do_cmd(2'b01, 2);
    chk_blk(2, 16'h0002, "R3 clear of locked-down at wp high gives 110, R2");
    set_wp(1'b0);
    chk_blk(2, 16'h0003, "R7 fall forces 110 locked");
    chk_blk(1, 16'h0000, "R7 fall keeps unlocked non-lock-down block");
  endtask

  task automatic t_history;
    set_wp(1'b1);
    chk_blk(2, 16'h0002, "R6 rise restores 110 from history");
    chk_blk(0, 16'h0003, "R6 rise gives 111 without history");
    do_cmd(2'b00, 2);
    chk_blk(2, 16'h0003, "R3 set lock 110 to 111");
    set_wp(1'b0);
    chk_blk(2, 16'h0003, "R7 fall from 111");
    set_wp(1'b1);
    chk_blk(2, 16'h0003, "R6 history overwritten by later fall");
  endtask

  task automatic t_same_cycle;
    set_wp(1'b0);
    do_cmd(2'b10, 5);
    chk_blk(5, 16'h0003, "R4 lock-down block 5");
    // rising edge and clear lock together: edge to 111, then clear to 110
    @(negedge clk);
    wp_lvl  = 1'b1;
    cmd_vld = 1'b1;
    cmd_op  = 2'b01;
    cmd_blk = 5'd5;
    @(negedge clk);
    cmd_vld = 1'b0;
    chk_blk(5, 16'h0002, "R9 edge applied before command");
    do_cmd(2'b10, 6);
    chk_blk(6, 16'h0003, "R4 lock-down at wp high gives 111");
  endtask

  initial begin
    rst_n   = 1'b0;
    wp_lvl  = 1'b0;
    cmd_vld = 1'b0;
    cmd_op  = 2'b00;
    cmd_blk = '0;
    qry_blk = '0;
    cfg_blk = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock_cmds();
    t_lockdown_low();
    t_range();
    t_rise_fall();
    t_history();
    t_same_cycle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule